// File: doc/BRIEF.md
# Four-Function Arithmetic Logic Unit with Overflow Flags

A purely combinational N-bit arithmetic logic unit (default width 4). A 2-bit operation code picks one of four results: the sum of the operands, their difference, their bitwise AND, or their bitwise OR. All four results are always formed side by side, and a final multiplexer passes only the selected one to the result port.

Addition and subtraction share one ripple-carry chain of 1-bit full adders. For subtraction, the second operand goes through a row of XOR gates driven by a subtract control, which inverts it. The same control is also fed in as the carry-in of bit 0, which forms the two's complement.

Alongside the result the block reports the carry out of the top bit, an unsigned-overflow flag and a signed-overflow flag. The flags carry meaning only for the arithmetic operations and are held at 0 for the logical ones.

Top module: `alu_four_fn`

## Requirements
- R1: With op_i = 2'b00, res_o equals (a_i + b_i) mod 2^N.
- R2: With op_i = 2'b01, res_o equals (a_i - b_i) mod 2^N.
- R3: With op_i = 2'b10, res_o equals a_i AND b_i, bit by bit.
- R4: With op_i = 2'b11, res_o equals a_i OR b_i, bit by bit.
- R5: For the arithmetic codes, carry_o is the carry out of the most significant bit of the shared adder. For addition it is 1 exactly when a_i + b_i >= 2^N. For subtraction, which adds the inverted b_i plus 1, it is 1 exactly when a_i >= b_i as unsigned values.
- R6: uovf_o equals carry_o for addition and equals the inverse of carry_o for subtraction. It is therefore 1 on a subtraction exactly when a_i < b_i as unsigned values.
- R7: sovf_o is 1 exactly when the two's-complement result of the add or subtract lies outside the signed N-bit range. At N=4, 0111+0001 and 1000+1111 both set it.
- R8: For op_i = 2'b10 and 2'b11, carry_o, uovf_o and sovf_o are all 0.
- R9: Subtracting zero returns a_i unchanged, with carry_o = 1 and uovf_o = 0, for every value of a_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand (the subtrahend for subtraction) |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| res_o | output | N | Selected result |
| carry_o | output | 1 | Carry out of the most significant bit (0 for logical codes) |
| uovf_o | output | 1 | Unsigned overflow flag (0 for logical codes) |
| sovf_o | output | 1 | Signed overflow flag (0 for logical codes) |

## Verification
Signed overflow is the hardest condition to reach from the ports. It needs the carry into the top bit and the carry out of it to differ, and in subtraction that depends on the inverted second operand rather than on the value applied. Directed vectors hit both directions for addition and subtraction, including the most negative operand. An exhaustive sweep of all 256 operand pairs under each of the four codes at N=4 then compares every output against a model built on signed ranges and unsigned comparisons. Subtraction of zero gets its own sweep, because only a carry-in of 1 can produce its carry-out of 1.

// File: rtl/alu_four_fn_pkg.sv
package alu_four_fn_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  assign sum_o  = x_i ^ y_i ^ cin_i;
  assign cout_o = (x_i & y_i) | (cin_i & (x_i ^ y_i));
endmodule

// File: rtl/alu_addsub_chain.sv
module alu_addsub_chain #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);
  logic [N:0]   carry;
  logic [N-1:0] b_x;

  assign b_x      = b_i ^ {N{sub_i}};
  assign carry[0] = sub_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    alu_fa_cell u_fa (
      .x_i   (a_i[i]),
      .y_i   (b_x[i]),
      .cin_i (carry[i]),
      .sum_o (sum_o[i]),
      .cout_o(carry[i+1])
    );
  end

  assign cout_o = carry[N];
  assign cmsb_o = carry[N-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] and_o,
  output logic [N-1:0] or_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
endmodule

// File: rtl/alu_four_fn.sv
module alu_four_fn
  import alu_four_fn_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [N-1:0] res_o,
  output logic         carry_o,
  output logic         uovf_o,
  output logic         sovf_o
);
  localparam int MSB = N - 1;

  alu_op_e      op;
  logic         sub;
  logic [N-1:0] arith;
  logic [N-1:0] and_r;
  logic [N-1:0] or_r;
  logic         c_out;
  logic         c_msb;

  assign op  = alu_op_e'(op_i);
  assign sub = (op == OP_SUB);

  alu_addsub_chain #(.N(N)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub),
    .sum_o (arith),
    .cout_o(c_out),
    .cmsb_o(c_msb)
  );

  alu_logic_unit #(.N(N)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .and_o(and_r),
    .or_o (or_r)
  );

  // result select; flags only live for arithmetic codes
  always_comb begin
    res_o   = arith;
    carry_o = 1'b0;
    uovf_o  = 1'b0;
    sovf_o  = 1'b0;
    unique case (op)
      OP_ADD: begin
        carry_o = c_out;
        uovf_o  = c_out;
        sovf_o  = c_msb ^ c_out;
      end
      OP_SUB: begin
        carry_o = c_out;
        uovf_o  = ~c_out;
        sovf_o  = c_msb ^ c_out;
      end
      OP_AND: res_o = and_r;
      OP_OR:  res_o = or_r;
      default: ;
    endcase
  end

  if (N < 2) begin : g_bad_width
    initial $error("alu_four_fn: N must be at least 2, MSB=%0d", MSB);
  end
endmodule

// File: rtl/alu_four_fn_chk.sv
module alu_four_fn_chk #(
  parameter int N = 4
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [1:0]   op_i,
  input logic [N-1:0] res_o,
  input logic         carry_o,
  input logic         uovf_o,
  input logic         sovf_o
);
  logic [N:0] wide_add;
  logic       a_neg, b_neg, r_neg;

  always_comb begin
    wide_add = {1'b0, a_i} + {1'b0, b_i};
    a_neg    = a_i[N-1];
    b_neg    = b_i[N-1];
    r_neg    = res_o[N-1];
    if (op_i == 2'b00) begin
      assert_sum_R1: assert ({carry_o, res_o} == wide_add);
      assert_add_uovf_R6: assert (uovf_o == carry_o);
      assert_add_sovf_R7: assert (sovf_o == ((a_neg == b_neg) && (r_neg != a_neg)));
    end
    if (op_i == 2'b01) begin
      assert_diff_R2: assert (res_o == N'(a_i - b_i));
      assert_sub_carry_R5: assert (carry_o == (a_i >= b_i));
      assert_sub_uovf_R6: assert (uovf_o == !carry_o);
      assert_sub_sovf_R7: assert (sovf_o == ((a_neg != b_neg) && (r_neg != a_neg)));
    end
    if (op_i == 2'b10) begin
      assert_and_R3: assert (res_o == (a_i & b_i));
    end
    if (op_i == 2'b11) begin
      assert_or_R4: assert (res_o == (a_i | b_i));
    end
    if (op_i[1]) begin
      assert_no_flags_R8: assert (!carry_o && !uovf_o && !sovf_o);
    end
  end
endmodule

bind alu_four_fn alu_four_fn_chk #(.N(N)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .op_i   (op_i),
  .res_o  (res_o),
  .carry_o(carry_o),
  .uovf_o (uovf_o),
  .sovf_o (sovf_o)
);

// File: tb/alu_four_fn_tb_top.sv
module alu_four_fn_tb_top;
  localparam int N  = 4;
  localparam int NV = 12;
  // {op[2], a[4], b[4], res[4], carry, uovf, sovf}
  localparam logic [16:0] VEC [NV] = '{
    {2'b00, 4'h7, 4'h1, 4'h8, 3'b001},
    {2'b00, 4'h8, 4'hF, 4'h7, 3'b111},
    {2'b00, 4'h3, 4'h4, 4'h7, 3'b000},
    {2'b00, 4'hF, 4'h1, 4'h0, 3'b110},
    {2'b01, 4'h5, 4'h3, 4'h2, 3'b100},
    {2'b01, 4'h3, 4'h5, 4'hE, 3'b010},
    {2'b01, 4'h8, 4'h1, 4'h7, 3'b101},
    {2'b01, 4'h7, 4'hF, 4'h8, 3'b011},
    {2'b01, 4'h6, 4'h0, 4'h6, 3'b100},
    {2'b10, 4'hC, 4'hA, 4'h8, 3'b000},
    {2'b11, 4'hC, 4'hA, 4'hE, 3'b000},
    {2'b10, 4'hF, 4'hF, 4'hF, 3'b000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] a, b, res;
  logic [1:0]   op;
  logic         carry, uovf, sovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu_four_fn #(.N(N)) dut_i (
    .a_i(a), .b_i(b), .op_i(op),
    .res_o(res), .carry_o(carry), .uovf_o(uovf), .sovf_o(sovf)
  );

  task automatic check(input string tag, input logic [N-1:0] r_e,
                       input logic c_e, input logic u_e, input logic s_e);
    checks++;
    if (res !== r_e || carry !== c_e || uovf !== u_e || sovf !== s_e) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h: got r=%h c=%b u=%b s=%b exp r=%h c=%b u=%b s=%b",
               tag, op, a, b, res, carry, uovf, sovf, r_e, c_e, u_e, s_e);
    end
  endtask

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   return "R1 R5 R6 R7";
      2'b01:   return "R2 R5 R6 R7";
      2'b10:   return "R3 R8";
      default: return "R4 R8";
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; op = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 4'h0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    // directed vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, a, b} = VEC[i][16:7];
      #2;
      check(op_tag(op), VEC[i][6:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // exhaustive sweep against an independent model
    for (int o = 0; o < 4; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          logic [N-1:0] r_e;
          logic c_e, u_e, s_e;
          op = 2'(o); a = 4'(x); b = 4'(y);
          #1;
          c_e = 1'b0; u_e = 1'b0; s_e = 1'b0;
          case (o)
            0: begin
              r_e = 4'(x + y);
              c_e = (x + y) >= 16;
              u_e = c_e;
              s_e = (a[3] == b[3]) && (r_e[3] != a[3]);
            end
            1: begin
              r_e = 4'(x - y);
              c_e = x >= y;
              u_e = x < y;
              s_e = (a[3] != b[3]) && (r_e[3] != a[3]);
            end
            2: r_e = 4'(x & y);
            default: r_e = 4'(x | y);
          endcase
          check(op_tag(2'(o)), r_e, c_e, u_e, s_e);
        end
      end
    end

    // subtract zero: carry from injected carry-in
    for (int x = 0; x < 16; x++) begin
      op = 2'b01; a = 4'(x); b = 4'h0;
      #1;
      check("R9", 4'(x), 1'b1, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule